// File: doc/BRIEF.md
# GPIO Bank with Per-Pin Interrupt Detection

This block is a single 32-pin general-purpose I/O bank behind a small memory-mapped register file. Software sets the value driven on each pin and whether the pin drives at all. It reads back the synchronised pin levels. For each pin it can choose one of four interrupt conditions: rising edge, falling edge, high level or low level.

A pin can latch an event into the sticky status register only when two separate gates are both open: its routing bit and its enable bit. The bank raises one combined interrupt line for as long as any status bit is set. Each register sits at a base address and has two companion addresses. One ORs the written bits in and the other clears them, so single bits can be changed without a read-modify-write. Writing a status bit through the clear address acknowledges that pin's interrupt.

Pin inputs cross into the clock domain through a two-stage synchroniser. A third register stage keeps the previous sample, and edge detection compares the two samples.

Top module: `gpio_irq_bank`

## Requirements
- R1: After reset every stored register reads 0, so no pin drives (`pin_oe_o` is 0), interrupts are masked and `irq_o` is low.
- R2: A byte address is register index × 16 plus an operation × 4, and bits [1:0] must be 0. Operation 0 writes the data, 1 ORs it in, and 2 AND-NOTs it. Operation 3, a misaligned address, or an address at or above 128 changes nothing. A read at any operation slot of an index returns that register, and an address outside the map reads 0.
- R3: `pin_out_o` equals the output-data register (index 0) and `pin_oe_o` equals the output-enable register (index 1) in the cycle after the write edge.
- R4: The input register (index 2) returns the pin levels after two synchroniser stages. A change shows on the second rising edge after it, and writes to index 2 have no effect.
- R5: With level bit 0 (index 3), polarity bit 1 (index 4) selects rising-edge detection and polarity bit 0 selects falling-edge detection. Edges are found between consecutive synchronised samples.
- R6: With level bit 1, polarity 1 detects an active-high level and polarity 0 an active-low level.
- R7: A detected event sets status bit n only if routing bit n (index 5) and enable bit n (index 6) are both 1.
- R8: Status (index 7) is sticky until cleared by a bus write, and a clear-alias write acknowledges it. A detection in the same cycle as a clear wins, so a persisting active level re-asserts status right away.
- R9: `irq_o` is high exactly while any status bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bank clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr_i | input | 1 | Write strobe, one write per cycle |
| bus_addr_i | input | 8 | Byte address (index × 16 + op × 4) |
| bus_wdata_i | input | 32 | Write data, bit n for pin n |
| bus_rdata_o | output | 32 | Combinational read data for `bus_addr_i` |
| pin_i | input | 32 | Asynchronous pin levels |
| pin_out_o | output | 32 | Value to drive on each pin |
| pin_oe_o | output | 32 | Per-pin drive enable, 1 drives |
| irq_o | output | 1 | Combined bank interrupt |

## Verification
The status assertions assume that a cycle without a bus write is the only kind of cycle in which status can be judged on detection alone. They also assume that detection uses only registered samples, so pin changes at any time inside a cycle are legal. The stimulus moves pins and the bus shortly after a rising edge and keeps both stable for the rest of the cycle. It holds reset from time zero so that no past-value check sees pre-reset state. Pin changes are spaced at least three edges apart whenever a directed check expects a single edge to be seen.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int NREGS = 8;
  localparam int IDX_W = $clog2(NREGS);

  typedef enum logic [1:0] {
    OP_WRITE = 2'd0,
    OP_SET   = 2'd1,
    OP_CLEAR = 2'd2,
    OP_NONE  = 2'd3
  } acc_op_e;

  typedef enum logic [IDX_W-1:0] {
    RI_DOUT  = 3'd0,
    RI_OE    = 3'd1,
    RI_DIN   = 3'd2,
    RI_LVL   = 3'd3,
    RI_POL   = 3'd4,
    RI_ROUTE = 3'd5,
    RI_IEN   = 3'd6,
    RI_STAT  = 3'd7
  } reg_idx_e;
endpackage

// File: rtl/gpio_bank_sync.sv
module gpio_bank_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin_i,
  output logic [W-1:0] samp_o,
  output logic [W-1:0] prev_o
);
  localparam int DEPTH = STAGES + 1;

  logic [W-1:0] stg_q [DEPTH];
  logic [W-1:0] stg_d [DEPTH];

  always_comb begin
    stg_d[0] = pin_i;
    for (int i = 1; i < DEPTH; i++) stg_d[i] = stg_q[i-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) stg_q[i] <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) stg_q[i] <= stg_d[i];
    end
  end

  assign samp_o = stg_q[STAGES-1];
  assign prev_o = stg_q[STAGES];
endmodule

// File: rtl/gpio_bank_detect.sv
module gpio_bank_detect #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] samp_i,
  input  logic [W-1:0] prev_i,
  input  logic [W-1:0] lvl_i,
  input  logic [W-1:0] pol_i,
  input  logic [W-1:0] route_i,
  input  logic [W-1:0] ien_i,
  output logic [W-1:0] hit_o
);
  for (genvar g = 0; g < W; g++) begin : g_pin
    logic raw;
    always_comb begin
      unique case ({lvl_i[g], pol_i[g]})
        2'b00:   raw = ~samp_i[g] &  prev_i[g];
        2'b01:   raw =  samp_i[g] & ~prev_i[g];
        2'b10:   raw = ~samp_i[g];
        default: raw =  samp_i[g];
      endcase
      hit_o[g] = raw & route_i[g] & ien_i[g];
    end
  end

  // R5
  edge_needs_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((hit_o & ~lvl_i & ~(samp_i ^ prev_i)) == '0));
endmodule

// File: rtl/gpio_bank_csr.sv
module gpio_bank_csr
  import gpio_bank_pkg::*;
#(
  parameter int W  = 32,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_i,
  input  logic [AW-1:0] addr_i,
  input  logic [W-1:0]  wdata_i,
  input  logic [W-1:0]  din_i,
  input  logic [W-1:0]  hit_i,
  output logic [W-1:0]  rdata_o,
  output logic [W-1:0]  dout_o,
  output logic [W-1:0]  oe_o,
  output logic [W-1:0]  lvl_o,
  output logic [W-1:0]  pol_o,
  output logic [W-1:0]  route_o,
  output logic [W-1:0]  ien_o,
  output logic [W-1:0]  stat_o
);
  localparam int IDX_LSB = 4;
  localparam int MAP_TOP = IDX_LSB + IDX_W;

  logic [W-1:0]     reg_q [NREGS];
  logic [W-1:0]     reg_d [NREGS];
  logic [NREGS-1:0] wr_en;
  logic [IDX_W-1:0] idx;
  acc_op_e          op;
  logic             in_map;
  logic             sel;

  function automatic logic [W-1:0] apply_op(input logic [W-1:0] old,
                                            input logic [W-1:0] wd,
                                            input acc_op_e      o);
    case (o)
      OP_SET:   return old | wd;
      OP_CLEAR: return old & ~wd;
      default:  return wd;
    endcase
  endfunction

  assign idx    = addr_i[MAP_TOP-1:IDX_LSB];
  assign op     = acc_op_e'(addr_i[IDX_LSB-1:2]);
  assign in_map = (addr_i[AW-1:MAP_TOP] == '0) && (addr_i[1:0] == 2'b00);
  assign sel    = wr_i && in_map && (op != OP_NONE);

  always_comb begin
    for (int r = 0; r < NREGS; r++) begin
      wr_en[r] = sel && (idx == IDX_W'(r)) && (r != int'(RI_DIN));
      reg_d[r] = wr_en[r] ? apply_op(reg_q[r], wdata_i, op) : reg_q[r];
    end
    reg_d[RI_STAT] = reg_d[RI_STAT] | hit_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < NREGS; r++) reg_q[r] <= '0;
    end else begin
      for (int r = 0; r < NREGS; r++) begin
        if (wr_en[r] || (r == int'(RI_STAT))) reg_q[r] <= reg_d[r];
      end
    end
  end

  always_comb begin
    if (!in_map)             rdata_o = '0;
    else if (idx == RI_DIN)  rdata_o = din_i;
    else                     rdata_o = reg_q[idx];
  end

  assign dout_o  = reg_q[RI_DOUT];
  assign oe_o    = reg_q[RI_OE];
  assign lvl_o   = reg_q[RI_LVL];
  assign pol_o   = reg_q[RI_POL];
  assign route_o = reg_q[RI_ROUTE];
  assign ien_o   = reg_q[RI_IEN];
  assign stat_o  = reg_q[RI_STAT];

  // R2
  plain_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en[RI_OE] && op == OP_WRITE) |=> (reg_q[RI_OE] == $past(wdata_i)));

  // R7
  gated_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel) |=> ((reg_q[RI_STAT] & ~$past(reg_q[RI_STAT])
                 & ~$past(reg_q[RI_ROUTE] & reg_q[RI_IEN])) == '0));

  // R8
  status_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel) |=> (($past(reg_q[RI_STAT]) & ~reg_q[RI_STAT]) == '0));
endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank #(
  parameter int NPINS       = 32,
  parameter int ADDR_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [NPINS-1:0]  bus_wdata_i,
  output logic [NPINS-1:0]  bus_rdata_o,
  input  logic [NPINS-1:0]  pin_i,
  output logic [NPINS-1:0]  pin_out_o,
  output logic [NPINS-1:0]  pin_oe_o,
  output logic              irq_o
);
  logic [NPINS-1:0] samp, prev, hit;
  logic [NPINS-1:0] lvl, pol, route, ien, stat;

  gpio_bank_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .samp_o(samp), .prev_o(prev)
  );

  gpio_bank_detect #(.W(NPINS)) u_detect (
    .clk(clk), .rst_n(rst_n), .samp_i(samp), .prev_i(prev),
    .lvl_i(lvl), .pol_i(pol), .route_i(route), .ien_i(ien), .hit_o(hit)
  );

  gpio_bank_csr #(.W(NPINS), .AW(ADDR_W)) u_csr (
    .clk(clk), .rst_n(rst_n), .wr_i(bus_wr_i), .addr_i(bus_addr_i),
    .wdata_i(bus_wdata_i), .din_i(samp), .hit_i(hit), .rdata_o(bus_rdata_o),
    .dout_o(pin_out_o), .oe_o(pin_oe_o), .lvl_o(lvl), .pol_o(pol),
    .route_o(route), .ien_o(ien), .stat_o(stat)
  );

  assign irq_o = |stat;

  // R9
  irq_follows_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_o) |-> ($past(stat) != '0) && (stat == '0));
endmodule

// File: tb/sim_gpio_irq_bank.sv
module sim_gpio_irq_bank;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_wr;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [31:0] pin_in;
  logic [31:0] pin_out;
  logic [31:0] pin_oe;
  logic        irq;

  always #5 clk = ~clk;

  gpio_irq_bank u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr_i(bus_wr), .bus_addr_i(bus_addr),
    .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata), .pin_i(pin_in),
    .pin_out_o(pin_out), .pin_oe_o(pin_oe), .irq_o(irq)
  );

  int compared = 0;
  int mismatched = 0;
  bit running = 0;
  bit finished = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Behavioural reference: register values plus a history of pin samples.
  logic [31:0] m [8];
  logic [31:0] hist [$];
  logic [31:0] ev, nv, cur, old;

  function automatic logic [31:0] model_read(input logic [7:0] a);
    if (a[7] || a[1:0] != 2'b00) return 32'h0;
    if (a[6:4] == 3'd2) return hist[1];
    return m[a[6:4]];
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 8; i++) m[i] = 32'h0;
      hist = '{32'h0, 32'h0, 32'h0};
    end else begin
      cur = hist[1];
      old = hist[2];
      ev = 32'h0;
      for (int b = 0; b < 32; b++) begin
        bit e;
        if (m[3][b]) e = m[4][b] ? cur[b] : !cur[b];
        else         e = m[4][b] ? (cur[b] && !old[b]) : (!cur[b] && old[b]);
        if (e && m[5][b] && m[6][b]) ev[b] = 1'b1;
      end
      if (bus_wr && !bus_addr[7] && bus_addr[1:0] == 2'b00 &&
          bus_addr[3:2] != 2'd3 && bus_addr[6:4] != 3'd2) begin
        nv = m[bus_addr[6:4]];
        case (bus_addr[3:2])
          2'd0: nv = bus_wdata;
          2'd1: nv = nv | bus_wdata;
          default: nv = nv & ~bus_wdata;
        endcase
        m[bus_addr[6:4]] = nv;
      end
      m[7] = m[7] | ev;
      hist = '{pin_in, hist[0], hist[1]};
    end
  end

  always @(negedge clk) begin
    if (running) begin
      chk("R3 pin_out", pin_out, m[0]);
      chk("R3 pin_oe", pin_oe, m[1]);
      chk("R9 irq", {31'h0, irq}, {31'h0, (m[7] != 32'h0)});
      chk("R2 rdata", bus_rdata, model_read(bus_addr));
    end
  end

  function automatic logic [7:0] A(input int idx, input int op);
    return 8'(idx * 16 + op * 4);
  endfunction

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    step();
    bus_wr = 1'b0;
  endtask

  task automatic rd(input string tag, input logic [7:0] a, input logic [31:0] exp);
    bus_addr = a;
    #1;
    chk(tag, bus_rdata, exp);
  endtask

  task automatic settle();
    repeat (4) step();
  endtask

  initial begin
    rst_n = 1'b0; bus_wr = 1'b0; bus_addr = 8'h0; bus_wdata = 32'h0; pin_in = 32'h0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    running = 1;
    step();

    // R1 reset state
    for (int i = 0; i < 8; i++) rd("R1 reset reg", A(i, 0), 32'h0);
    chk("R1 oe after reset", pin_oe, 32'h0);
    chk("R1 irq after reset", {31'h0, irq}, 32'h0);

    // R2 aliases, R3 pins
    wr(A(0, 0), 32'hF0F0_0000);
    wr(A(0, 1), 32'h0000_00FF);
    wr(A(0, 2), 32'hF000_0001);
    rd("R2 write/set/clear", A(0, 0), 32'h00F0_00FE);
    rd("R2 read via set slot", A(0, 1), 32'h00F0_00FE);
    rd("R2 read via clear slot", A(0, 2), 32'h00F0_00FE);
    wr(A(0, 3), 32'hFFFF_FFFF);
    rd("R2 op3 ignored", A(0, 0), 32'h00F0_00FE);
    wr(8'h81, 32'hFFFF_FFFF);
    wr(8'h01, 32'hFFFF_FFFF);
    rd("R2 misaligned/out-of-map ignored", A(0, 0), 32'h00F0_00FE);
    rd("R2 out-of-map reads zero", 8'h80, 32'h0);
    chk("R3 pin_out", pin_out, 32'h00F0_00FE);
    wr(A(1, 0), 32'h0000_FFFF);
    chk("R3 pin_oe", pin_oe, 32'h0000_FFFF);

    // R4 synchroniser latency and read-only input register
    pin_in = 32'hA5A5_5A5A;
    step();
    rd("R4 one edge later still old", A(2, 0), 32'h0);
    step();
    rd("R4 two edges later new", A(2, 0), 32'hA5A5_5A5A);
    wr(A(2, 0), 32'h0);
    rd("R4 write ignored", A(2, 0), 32'hA5A5_5A5A);
    settle();
    rd("R7 no status without gates", A(7, 0), 32'h0);

    // R7 gating with pin 0 rising edge (R5)
    wr(A(4, 1), 32'h1);
    wr(A(5, 1), 32'h1);
    pin_in[0] = 1'b1; settle();
    rd("R7 route only blocks", A(7, 0), 32'h0);
    pin_in[0] = 1'b0; settle();
    wr(A(5, 2), 32'h1);
    wr(A(6, 1), 32'h1);
    pin_in[0] = 1'b1; settle();
    rd("R7 enable only blocks", A(7, 0), 32'h0);
    pin_in[0] = 1'b0; settle();
    wr(A(5, 1), 32'h1);
    rd("R5 falling ignored in rising mode", A(7, 0), 32'h0);
    pin_in[0] = 1'b1; settle();
    rd("R5 rising edge latched", A(7, 0), 32'h1);
    chk("R9 irq high", {31'h0, irq}, 32'h1);

    // R8 sticky then acknowledge
    settle();
    rd("R8 sticky", A(7, 0), 32'h1);
    wr(A(7, 2), 32'h1);
    rd("R8 ack clears", A(7, 0), 32'h0);
    chk("R9 irq low", {31'h0, irq}, 32'h0);

    // R5 falling edge on pin 1
    wr(A(5, 1), 32'h2);
    wr(A(6, 1), 32'h2);
    pin_in[1] = 1'b0; settle();
    rd("R5 falling edge latched", A(7, 0), 32'h2);
    wr(A(7, 2), 32'h2);

    // R6 active-low level on pin 2 (pin currently low)
    wr(A(3, 1), 32'h4);
    wr(A(5, 1), 32'h4);
    wr(A(6, 1), 32'h4);
    step();
    rd("R6 active-low level", A(7, 0), 32'h4);
    wr(A(7, 2), 32'h4);
    rd("R8 level re-asserts over clear", A(7, 0), 32'h4);
    pin_in[2] = 1'b1; settle();
    wr(A(7, 2), 32'h4);
    settle();
    rd("R6 inactive level stays clear", A(7, 0), 32'h0);
    wr(A(4, 1), 32'h4);
    step();
    rd("R6 active-high level", A(7, 0), 32'h4);
    wr(A(6, 0), 32'h0);
    wr(A(7, 0), 32'h0);
    rd("R2 plain write clears status", A(7, 0), 32'h0);
    chk("R9 irq low at end", {31'h0, irq}, 32'h0);

    settle();
    running = 0;
    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule